// File: doc/BRIEF.md
# Serial Token Packet Field Decoder

This block takes a token packet as a stream of bits that have already had NRZI decoding and bit unstuffing applied. Each packet is framed by a start marker on its first bit and an end marker in a separate cycle after its last bit. The first eight bits carry the packet identifier. The next eleven bits carry either a device address with an endpoint number or a frame number, depending on the identifier. The last five bits are a check code.

The block checks the identifier byte and works out which kind of token it is. It pulls the fields out of the bit stream and checks the 5-bit CRC over the eleven field bits and the five check bits. One cycle after the end marker it gives exactly one result strobe: a decoded token with its fields, a length error, an identifier error, or a CRC error. It is meant to sit behind the serial receive front end, and its result strobes feed the transaction logic.

Top module: `tok_field_decoder`

## Requirements
- R1: An identifier byte whose upper nibble is not the bitwise complement of its lower nibble raises `pid_err` and produces no token.
- R2: Only these lower-nibble codes are accepted as tokens: OUT 4'b0001, IN 4'b1001, SETUP 4'b1101 and start-of-frame 4'b0101. Any other well-formed identifier raises `pid_err`.
- R3: For OUT, IN and SETUP, stream bits 8..14 (first bit received is bit 0) form `addr`, least significant bit first. Bits 15..18 form `endp`, least significant bit first. `frame` reads zero.
- R4: For start-of-frame, stream bits 8..18 form `frame`, least significant bit first, covering 0 to 0x7FF. `addr` and `endp` read zero.
- R5: The CRC uses x^5+x^2+1 with the register preset to 5'b11111. It is fed stream bits 8..23 only and never the identifier bits. A final register value other than 5'b01100 raises `crc_err` and suppresses `tok_valid`.
- R6: A packet whose bit count is not exactly 24 raises `len_err`. Error priority is length, then identifier, then CRC.
- R7: Results appear in the cycle after the end-marker cycle and last one cycle. At most one of `tok_valid`, `pid_err`, `len_err` and `crc_err` is high at a time. `tok_pid`, `addr`, `endp` and `frame` read zero whenever `tok_valid` is low.
- R8: Cycles with `bit_valid` low inside a packet add no bit and change no result, whatever `bit_data` carries.
- R9: Bits and end markers that arrive outside a packet are ignored. An end marker in the same cycle as a start marker is ignored. A new start marker drops any unfinished packet.
- R10: While reset is applied and just after it is released, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop | input | 1 | Start marker, high together with the first bit of a packet |
| bit_valid | input | 1 | `bit_data` carries a bit this cycle |
| bit_data | input | 1 | Serial bit, unstuffed |
| eop | input | 1 | End marker, a cycle with no bit after the last bit |
| tok_valid | output | 1 | Token decoded without error |
| tok_pid | output | 4 | Token code (lower identifier nibble) |
| addr | output | 7 | Device address |
| endp | output | 4 | Endpoint number |
| frame | output | 11 | Frame number |
| pid_err | output | 1 | Malformed or non-token identifier |
| len_err | output | 1 | Packet bit count not 24 |
| crc_err | output | 1 | CRC residual mismatch |

## Verification
Every address value is sent under the three addressed token kinds, with the endpoint varied alongside. Frame numbers are swept in steps across the full 11-bit range, including both ends. These sweeps show whether the field bit order and the field split between address and endpoint are right. All 256 identifier bytes are sent with a correct field and check code. This separates malformed bytes, well-formed non-token codes and the four token codes, and shows that the CRC does not depend on the identifier. Single-bit flips at each protected position, bit counts from 0 to 31, idle gaps inside packets, and stray bits or markers outside packets exercise the error priorities and the rules on what is ignored.

// File: rtl/tok_pkg.sv
package tok_pkg;
  localparam int PID_W  = 8;
  localparam int ADDR_W = 7;
  localparam int ENDP_W = 4;
  localparam int CRC_W  = 5;

  localparam logic [CRC_W-1:0] CRC_POLY  = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_INIT  = 5'b11111;
  localparam logic [CRC_W-1:0] CRC_RESID = 5'b01100;

  typedef enum logic [3:0] {
    CODE_OUT   = 4'b0001,
    CODE_IN    = 4'b1001,
    CODE_SOF   = 4'b0101,
    CODE_SETUP = 4'b1101
  } tok_code_e;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_FRAME = 2'd2
  } tok_kind_e;
endpackage

// File: rtl/tok_rst_sync.sv
module tok_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/tok_bit_counter.sv
module tok_bit_counter #(
  parameter int LIMIT = 24,
  parameter int CW    = $clog2(LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          first,
  input  logic          step,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

  logic [CW-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                   cnt_d = first ? CW'(1) : '0;
    else if (step && cnt_q < SAT)  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tok_crc_ser.sv
module tok_crc_ser #(
  parameter int                W    = 5,
  parameter logic [W-1:0]      POLY = 5'b00101,
  parameter logic [W-1:0]      INIT = 5'b11111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_d, crc_q;
  logic         fb;

  always_comb begin
    fb    = din ^ crc_q[W-1];
    crc_d = crc_q;
    if (clr)     crc_d = INIT;
    else if (en) crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/tok_pid_check.sv
module tok_pid_check
  import tok_pkg::*;
#(
  parameter int PID_BITS = PID_W,
  localparam int NIB     = PID_BITS / 2
) (
  input  logic [PID_BITS-1:0] pid,
  output logic                pid_ok,
  output tok_kind_e           kind
);
  logic [NIB-1:0] lo, hi;
  logic           formed;

  always_comb begin
    lo     = pid[NIB-1:0];
    hi     = pid[PID_BITS-1:NIB];
    formed = (hi == ~lo);
    case (lo)
      CODE_OUT, CODE_IN, CODE_SETUP: kind = KIND_ADDR;
      CODE_SOF:                      kind = KIND_FRAME;
      default:                       kind = KIND_NONE;
    endcase
    pid_ok = formed && (kind != KIND_NONE);
  end
endmodule

// File: rtl/tok_field_decoder.sv
module tok_field_decoder
  import tok_pkg::*;
#(
  parameter int                    PID_BITS  = PID_W,
  parameter int                    ADDR_BITS = ADDR_W,
  parameter int                    ENDP_BITS = ENDP_W,
  parameter int                    CRC_BITS  = CRC_W,
  parameter logic [CRC_BITS-1:0]   POLY      = CRC_POLY,
  parameter logic [CRC_BITS-1:0]   INIT      = CRC_INIT,
  parameter logic [CRC_BITS-1:0]   RESID     = CRC_RESID,
  localparam int                   NIB       = PID_BITS / 2,
  localparam int                   FLD_BITS  = ADDR_BITS + ENDP_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sop,
  input  logic                 bit_valid,
  input  logic                 bit_data,
  input  logic                 eop,
  output logic                 tok_valid,
  output logic [NIB-1:0]       tok_pid,
  output logic [ADDR_BITS-1:0] addr,
  output logic [ENDP_BITS-1:0] endp,
  output logic [FLD_BITS-1:0]  frame,
  output logic                 pid_err,
  output logic                 len_err,
  output logic                 crc_err
);
  localparam int PKT_LEN = PID_BITS + FLD_BITS + CRC_BITS;
  localparam int CW      = $clog2(PKT_LEN + 2);
  localparam logic [CW-1:0] FLD_LO = CW'(PID_BITS);
  localparam logic [CW-1:0] FLD_HI = CW'(PID_BITS + FLD_BITS);
  localparam logic [CW-1:0] PKT_END = CW'(PKT_LEN);

  logic                 rst_s_n;
  logic                 active_q, active_d;
  logic [CW-1:0]        cnt, idx;
  logic                 take, end_evt, pid_en, fld_en, crc_en;
  logic [PID_BITS-1:0]  pid_q, pid_d;
  logic [FLD_BITS-1:0]  fld_q, fld_d;
  logic [CRC_BITS-1:0]  crc_q;
  logic                 pid_ok, crc_ok;
  tok_kind_e            kind;

  logic                 valid_d, perr_d, lerr_d, cerr_d;
  logic [NIB-1:0]       tpid_d;
  logic [ADDR_BITS-1:0] addr_d;
  logic [ENDP_BITS-1:0] endp_d;
  logic [FLD_BITS-1:0]  frame_d;

  tok_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  tok_bit_counter #(.LIMIT(PKT_LEN), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .restart (sop),
    .first   (sop & bit_valid),
    .step    (take & ~sop),
    .cnt     (cnt)
  );

  tok_crc_ser #(.W(CRC_BITS), .POLY(POLY), .INIT(INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (sop),
    .en    (crc_en),
    .din   (bit_data),
    .crc   (crc_q)
  );

  tok_pid_check #(.PID_BITS(PID_BITS)) u_pid (
    .pid    (pid_q),
    .pid_ok (pid_ok),
    .kind   (kind)
  );

  // bit routing and packet framing
  always_comb begin
    take     = bit_valid & (sop | (active_q & ~eop));
    end_evt  = eop & active_q & ~sop;
    idx      = sop ? '0 : cnt;
    pid_en   = take && (idx < FLD_LO);
    fld_en   = take && (idx >= FLD_LO) && (idx < FLD_HI);
    crc_en   = take && (idx >= FLD_LO) && (idx < PKT_END);
    active_d = active_q;
    if (sop)          active_d = 1'b1;
    else if (end_evt) active_d = 1'b0;
    pid_d = pid_en ? {bit_data, pid_q[PID_BITS-1:1]} : pid_q;
    fld_d = fld_en ? {bit_data, fld_q[FLD_BITS-1:1]} : fld_q;
    crc_ok = (crc_q == RESID);
  end

  // result decision
  always_comb begin
    valid_d = 1'b0;
    perr_d  = 1'b0;
    lerr_d  = 1'b0;
    cerr_d  = 1'b0;
    tpid_d  = '0;
    addr_d  = '0;
    endp_d  = '0;
    frame_d = '0;
    if (end_evt) begin
      if (cnt != PKT_END)  lerr_d = 1'b1;
      else if (!pid_ok)    perr_d = 1'b1;
      else if (!crc_ok)    cerr_d = 1'b1;
      else begin
        valid_d = 1'b1;
        tpid_d  = pid_q[NIB-1:0];
        if (kind == KIND_FRAME) begin
          frame_d = fld_q;
        end else begin
          addr_d = fld_q[ADDR_BITS-1:0];
          endp_d = fld_q[FLD_BITS-1:ADDR_BITS];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      active_q  <= 1'b0;
      pid_q     <= '0;
      fld_q     <= '0;
      tok_valid <= 1'b0;
      pid_err   <= 1'b0;
      len_err   <= 1'b0;
      crc_err   <= 1'b0;
      tok_pid   <= '0;
      addr      <= '0;
      endp      <= '0;
      frame     <= '0;
    end else begin
      active_q  <= active_d;
      pid_q     <= pid_d;
      fld_q     <= fld_d;
      tok_valid <= valid_d;
      pid_err   <= perr_d;
      len_err   <= lerr_d;
      crc_err   <= cerr_d;
      tok_pid   <= tpid_d;
      addr      <= addr_d;
      endp      <= endp_d;
      frame     <= frame_d;
    end
  end
endmodule

// File: rtl/tok_field_decoder_chk.sv
module tok_field_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sop,
  input logic        eop,
  input logic        tok_valid,
  input logic [3:0]  tok_pid,
  input logic [6:0]  addr,
  input logic [3:0]  endp,
  input logic [10:0] frame,
  input logic        pid_err,
  input logic        len_err,
  input logic        crc_err
);
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tok_valid, pid_err, len_err, crc_err}));

  // R7
  strobe_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid | pid_err | len_err | crc_err) |-> $past(eop));

  // R9
  no_eop_with_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid | pid_err | len_err | crc_err) |-> !$past(sop));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> !tok_valid);

  // R7
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |-> (tok_pid == 4'd0 && addr == 7'd0 && endp == 4'd0 && frame == 11'd0));

  // R2
  token_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> (tok_pid == 4'b0001 || tok_pid == 4'b1001 ||
                   tok_pid == 4'b1101 || tok_pid == 4'b0101));

  // R4
  sof_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_pid == 4'b0101) |-> (addr == 7'd0 && endp == 4'd0));

  // R3
  addr_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_pid != 4'b0101) |-> (frame == 11'd0));
endmodule

bind tok_field_decoder tok_field_decoder_chk u_chk (.*);

// File: tb/tok_field_decoder_bench.sv
module tok_field_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        eop = 1'b0;
  logic        tok_valid, pid_err, len_err, crc_err;
  logic [3:0]  tok_pid;
  logic [6:0]  addr;
  logic [3:0]  endp;
  logic [10:0] frame;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tok_field_decoder u_tok_field_decoder (
    .clk(clk), .rst_n(rst_n), .sop(sop), .bit_valid(bit_valid),
    .bit_data(bit_data), .eop(eop), .tok_valid(tok_valid),
    .tok_pid(tok_pid), .addr(addr), .endp(endp), .frame(frame),
    .pid_err(pid_err), .len_err(len_err), .crc_err(crc_err)
  );

  function automatic logic [4:0] crc5(input logic [10:0] f);
    logic [4:0] c = 5'b11111;
    for (int i = 0; i < 11; i++) begin
      logic fb = f[i] ^ c[4];
      c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    return c;
  endfunction

  function automatic logic [31:0] make_pkt(input logic [7:0] pid, input logic [10:0] f);
    logic [31:0] p = '0;
    logic [4:0]  c = crc5(f);
    p[7:0]  = pid;
    p[18:8] = f;
    for (int i = 0; i < 5; i++) p[19+i] = ~c[4-i];
    return p;
  endfunction

  function automatic bit is_token(input logic [7:0] pid);
    return (pid[7:4] == ~pid[3:0]) &&
           (pid[3:0] == 4'b0001 || pid[3:0] == 4'b1001 ||
            pid[3:0] == 4'b1101 || pid[3:0] == 4'b0101);
  endfunction

  task automatic check_quiet(input string req);
    checks++;
    if (tok_valid | pid_err | len_err | crc_err | (|tok_pid) | (|addr) | (|endp) | (|frame)) begin
      errors++;
      $display("FAIL %s outputs not idle: got %b%b%b%b %h %h %h %h exp all zero",
               req, tok_valid, pid_err, len_err, crc_err, tok_pid, addr, endp, frame);
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n, input int gap);
    if (n == 0) begin
      @(negedge clk); sop = 1'b1; bit_valid = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sop = (i == 0); bit_valid = 1'b1; bit_data = bits[i];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); sop = 1'b0; bit_valid = 1'b0; bit_data = ~bits[i];
      end
    end
    @(negedge clk); sop = 1'b0; bit_valid = 1'b0; eop = 1'b1;
    @(negedge clk); eop = 1'b0;
  endtask

  task automatic run_pkt(input string req, input logic [7:0] pid, input logic [10:0] f,
                         input int flip, input int n, input int gap);
    logic [31:0] p = make_pkt(pid, f);
    logic [7:0]  ps;
    logic        ev, pe, le, ce;
    logic [3:0]  ep = '0;
    logic [6:0]  ea = '0;
    logic [3:0]  ee = '0;
    logic [10:0] ef = '0;
    logic [29:0] got, exp;
    if (flip >= 0) p[flip] = ~p[flip];
    ps = p[7:0];
    le = (n != 24);
    pe = !le && !is_token(ps);
    ce = !le && !pe && (flip >= 8);
    ev = !le && !pe && !ce;
    if (ev) begin
      ep = ps[3:0];
      if (ps[3:0] == 4'b0101) ef = f;
      else begin ea = f[6:0]; ee = f[10:7]; end
    end
    send(p, n, gap);
    got = {tok_valid, pid_err, len_err, crc_err, tok_pid, addr, endp, frame};
    exp = {ev, pe, le, ce, ep, ea, ee, ef};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pid=%h f=%h flip=%0d n=%0d got %h exp %h", req, pid, f, flip, n, got, exp);
    end
    @(negedge clk);
    check_quiet("R7");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] codes [3];
    codes[0] = 8'hE1; codes[1] = 8'h69; codes[2] = 8'h2D;

    // R10: reset state
    repeat (3) @(negedge clk);
    check_quiet("R10");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R10");

    // R3: every address under the three addressed tokens
    for (int a = 0; a < 128; a++)
      run_pkt("R3", codes[a % 3], {4'(a % 16), 7'(a)}, -1, 24, 0);
    for (int e = 0; e < 16; e++)
      run_pkt("R3", 8'h2D, {4'(e), 7'h55}, -1, 24, 0);

    // R4: frame numbers across the range
    for (int fr = 0; fr < 2048; fr += 37)
      run_pkt("R4", 8'hA5, 11'(fr), -1, 24, 0);
    run_pkt("R4", 8'hA5, 11'h7FF, -1, 24, 0);
    run_pkt("R4", 8'hA5, 11'h400, -1, 24, 0);

    // R1 R2: every identifier byte
    for (int p = 0; p < 256; p++)
      run_pkt(is_token(8'(p)) ? "R2" : "R1", 8'(p), 11'h2A5, -1, 24, 0);

    // R5: single flips in each protected bit, and in identifier bits
    for (int b = 8; b < 24; b++)
      run_pkt("R5", 8'h69, 11'h13C, b, 24, 0);
    for (int b = 0; b < 8; b++)
      run_pkt("R1", 8'h69, 11'h13C, b, 24, 0);

    // R6: every wrong length, with a good prefix and a bad identifier
    for (int n = 0; n < 32; n++)
      if (n != 24) run_pkt("R6", 8'hE1, 11'h0F3, -1, n, 0);
    run_pkt("R6", 8'h00, 11'h0F3, 3, 23, 0);

    // R8: idle cycles inside packets
    run_pkt("R8", 8'hE1, 11'h5A3, -1, 24, 1);
    run_pkt("R8", 8'hA5, 11'h6B1, -1, 24, 3);
    run_pkt("R8", 8'h2D, 11'h1FF, 12, 24, 2);

    // R9: stray bits and end marker outside a packet
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_valid = 1'b1; bit_data = i[0];
    end
    @(negedge clk); bit_valid = 1'b0; eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    check_quiet("R9");
    @(negedge clk);
    check_quiet("R9");

    // R9: end marker together with start marker is ignored
    @(negedge clk); sop = 1'b1; bit_valid = 1'b1; bit_data = 1'b1; eop = 1'b1;
    @(negedge clk); sop = 1'b0; bit_valid = 1'b0; eop = 1'b0;
    check_quiet("R9");
    @(negedge clk); eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    checks++;
    if (!len_err || tok_valid) begin
      errors++;
      $display("FAIL R9 one-bit packet after ignored eop: got len_err=%b tok_valid=%b exp 1 0",
               len_err, tok_valid);
    end

    // R9: unfinished packet dropped by a new start marker
    @(negedge clk); sop = 1'b1; bit_valid = 1'b1; bit_data = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); sop = 1'b0; bit_data = ~bit_data;
    end
    run_pkt("R9", 8'h69, 11'h3C7, -1, 24, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule